// File: doc/BRIEF.md
# PCM time-slot bit gate

This block sits between a serial channel and a frame-synchronized PCM highway. Receive and transmit share one bit clock, which reaches the block as a one-cycle enable `bit_en` in the system clock domain. On each bit tick the block samples a frame-sync input. A rising edge of that input starts a new frame and sets the frame bit position to zero. From then on the position counts bit ticks.

Receive and transmit each have their own window. A window opens at bit position `slot*8 + shift` and stays open for `wlen+1` bit ticks, so its width runs from 1 to 256 bits. There are 64 slots and eight shift values for each direction. Inside the receive window, incoming bits pass through with a valid strobe. Inside the transmit window, the line driver is enabled and the transmit bit is driven. Outside the windows the data outputs are forced to zero. Settings written while a frame runs are captured only at the next frame-sync edge. Data is taken as plain NRZ bits.

Each direction runs a window state machine with four states. `WIN_IDLE` holds until the first frame since reset. `WIN_SEEK` waits for the start position. `WIN_OPEN` is the window itself. `WIN_DONE` lasts for the rest of the frame. The transitions are:
- sync-restart: any state goes to `WIN_OPEN` on a frame edge when the start position is 0, and to `WIN_SEEK` otherwise.
- start-hit: `WIN_SEEK` goes to `WIN_OPEN` when the next position equals the start.
- width-spent: `WIN_OPEN` goes to `WIN_DONE` when its remaining-bit counter is zero.

Top module: `tsg_slot_gate`

## Requirements
- R1: After reset `frame_bit` is 4095, and `rx_win`, `tx_win`, `rx_valid`, `tx_oe`, `rx_dout` and `tx_pin` are all 0.
- R2: A frame edge occurs when `fsync` is 1 on a bit tick and was 0 on the previous bit tick. The previous sample counts as 1 right after reset. A frame edge sets `frame_bit` to 0, and an `fsync` level held high does not start another frame.
- R3: Each bit tick without a frame edge increments `frame_bit` by one, stopping at 4095. Cycles with `bit_en` low change neither `frame_bit` nor the windows.
- R4: `rx_win` is 1 exactly while `frame_bit` lies in [`rx_slot*8+rx_shift`, `rx_slot*8+rx_shift+rx_wlen`], with the settings captured at the last frame edge.
- R5: `tx_win` follows the same rule using `tx_slot`, `tx_shift` and `tx_wlen`, independently of the receive side.
- R6: `wlen` = 0 gives a window of one bit and `wlen` = 255 gives 256 bits. The largest start (slot 63, shift 7) is handled.
- R7: Setting changes between frame edges do not alter the running frame's windows. They apply from the next frame edge.
- R8: `rx_valid` equals `rx_win & bit_en`, and `rx_dout` equals `rx_din` when `rx_win` is 1 and 0 otherwise.
- R9: `tx_oe` equals `tx_win`, and `tx_pin` equals `tx_din` when `tx_win` is 1 and 0 otherwise.
- R10: A frame edge that arrives while a window is open restarts the frame. The windows are recomputed from position 0.
- R11: No window opens before the first frame edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-clock enable, one tick per bit |
| fsync | input | 1 | Frame-sync level, sampled on bit ticks |
| rx_slot | input | 6 | Receive slot index |
| rx_shift | input | 3 | Receive fine shift in bits |
| rx_wlen | input | 8 | Receive window width minus one |
| tx_slot | input | 6 | Transmit slot index |
| tx_shift | input | 3 | Transmit fine shift in bits |
| tx_wlen | input | 8 | Transmit window width minus one |
| rx_din | input | 1 | Serial receive bit from the highway |
| tx_din | input | 1 | Serial transmit bit from the channel |
| rx_win | output | 1 | Receive window open |
| rx_valid | output | 1 | Receive bit strobe inside the window |
| rx_dout | output | 1 | Gated receive bit |
| tx_win | output | 1 | Transmit window open |
| tx_oe | output | 1 | Transmit line driver enable |
| tx_pin | output | 1 | Gated transmit bit |
| frame_bit | output | 12 | Bit position within the current frame |

## Verification
Two events can fall on the same bit tick: a frame-sync edge and a window that is already open or just about to close. In that case the restart must take priority over the start-hit and width-spent transitions. The bench provokes this by raising `fsync` in the middle of an open receive window. It also changes the settings while a window is open. A reference model computes the expected window from its own position counter and its own captured settings. Every bit tick is compared against that model, so a late or skipped restart shows up as a window at the wrong position.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
    localparam int TSG_CNT_W     = 12;
    localparam int TSG_SLOT_W    = 6;
    localparam int TSG_SHIFT_W   = 3;
    localparam int TSG_WLEN_W    = 8;
    localparam int TSG_SLOT_BITS = 8;

    typedef enum logic [1:0] {
        WIN_IDLE,
        WIN_SEEK,
        WIN_OPEN,
        WIN_DONE
    } win_state_t;
endpackage

// File: rtl/tsg_frame_counter.sv
module tsg_frame_counter #(
    parameter int CNT_W = tsg_pkg::TSG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             fsync,
    output logic             sync_tick,
    output logic [CNT_W-1:0] pos,
    output logic [CNT_W-1:0] pos_next
);
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    logic fs_q;

    // rising edge of frame sync, judged only on bit ticks
    assign sync_tick = bit_en && fsync && !fs_q;

    always_comb begin
        if (sync_tick) begin
            pos_next = '0;
        end else if (pos == POS_MAX) begin
            pos_next = POS_MAX;
        end else begin
            pos_next = pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= 1'b1;
            pos  <= POS_MAX;
        end else if (bit_en) begin
            fs_q <= fsync;
            pos  <= pos_next;
        end
    end
endmodule

// File: rtl/tsg_slot_window.sv
module tsg_slot_window
    import tsg_pkg::*;
#(
    parameter int CNT_W     = TSG_CNT_W,
    parameter int SLOT_W    = TSG_SLOT_W,
    parameter int SHIFT_W   = TSG_SHIFT_W,
    parameter int WLEN_W    = TSG_WLEN_W,
    parameter int SLOT_BITS = TSG_SLOT_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               sync_tick,
    input  logic [CNT_W-1:0]   pos_next,
    input  logic [SLOT_W-1:0]  slot_in,
    input  logic [SHIFT_W-1:0] shift_in,
    input  logic [WLEN_W-1:0]  wlen_in,
    output logic               win
);
    localparam logic [CNT_W-1:0] SLOT_MUL = CNT_W'(SLOT_BITS);

    win_state_t          st_q, st_d;
    logic [WLEN_W-1:0]   rem_q, rem_d;
    logic [SLOT_W-1:0]   slot_q;
    logic [SHIFT_W-1:0]  shift_q;
    logic [WLEN_W-1:0]   wlen_q;
    logic [CNT_W-1:0]    start_in, start_q;

    assign start_in = CNT_W'(slot_in) * SLOT_MUL + CNT_W'(shift_in);
    assign start_q  = CNT_W'(slot_q)  * SLOT_MUL + CNT_W'(shift_q);

    // next-state logic: a frame edge overrides every state
    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        if (sync_tick) begin
            if (start_in == '0) begin
                st_d  = WIN_OPEN;
                rem_d = wlen_in;
            end else begin
                st_d  = WIN_SEEK;
            end
        end else begin
            unique case (st_q)
                WIN_IDLE: st_d = WIN_IDLE;
                WIN_SEEK: begin
                    if (pos_next == start_q) begin
                        st_d  = WIN_OPEN;
                        rem_d = wlen_q;
                    end
                end
                WIN_OPEN: begin
                    if (rem_q == '0) begin
                        st_d = WIN_DONE;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
                WIN_DONE: st_d = WIN_DONE;
                default:  st_d = WIN_IDLE;
            endcase
        end
    end

    // state register and settings captured at the frame edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= WIN_IDLE;
            rem_q   <= '0;
            slot_q  <= '0;
            shift_q <= '0;
            wlen_q  <= '0;
        end else if (bit_en) begin
            st_q  <= st_d;
            rem_q <= rem_d;
            if (sync_tick) begin
                slot_q  <= slot_in;
                shift_q <= shift_in;
                wlen_q  <= wlen_in;
            end
        end
    end

    // output decode
    always_comb begin
        win = (st_q == WIN_OPEN);
    end
endmodule

// File: rtl/tsg_slot_gate.sv
module tsg_slot_gate
    import tsg_pkg::*;
#(
    parameter int CNT_W     = TSG_CNT_W,
    parameter int SLOT_W    = TSG_SLOT_W,
    parameter int SHIFT_W   = TSG_SHIFT_W,
    parameter int WLEN_W    = TSG_WLEN_W,
    parameter int SLOT_BITS = TSG_SLOT_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               fsync,
    input  logic [SLOT_W-1:0]  rx_slot,
    input  logic [SHIFT_W-1:0] rx_shift,
    input  logic [WLEN_W-1:0]  rx_wlen,
    input  logic [SLOT_W-1:0]  tx_slot,
    input  logic [SHIFT_W-1:0] tx_shift,
    input  logic [WLEN_W-1:0]  tx_wlen,
    input  logic               rx_din,
    input  logic               tx_din,
    output logic               rx_win,
    output logic               rx_valid,
    output logic               rx_dout,
    output logic               tx_win,
    output logic               tx_oe,
    output logic               tx_pin,
    output logic [CNT_W-1:0]   frame_bit
);
    localparam int NDIR = 2;   // index 0 receive, 1 transmit

    logic               sync_tick;
    logic [CNT_W-1:0]   pos_next;
    logic [SLOT_W-1:0]  slot_a  [NDIR];
    logic [SHIFT_W-1:0] shift_a [NDIR];
    logic [WLEN_W-1:0]  wlen_a  [NDIR];
    logic               win_a   [NDIR];

    assign slot_a[0]  = rx_slot;
    assign slot_a[1]  = tx_slot;
    assign shift_a[0] = rx_shift;
    assign shift_a[1] = tx_shift;
    assign wlen_a[0]  = rx_wlen;
    assign wlen_a[1]  = tx_wlen;

    tsg_frame_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .fsync     (fsync),
        .sync_tick (sync_tick),
        .pos       (frame_bit),
        .pos_next  (pos_next)
    );

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        tsg_slot_window #(
            .CNT_W     (CNT_W),
            .SLOT_W    (SLOT_W),
            .SHIFT_W   (SHIFT_W),
            .WLEN_W    (WLEN_W),
            .SLOT_BITS (SLOT_BITS)
        ) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_en    (bit_en),
            .sync_tick (sync_tick),
            .pos_next  (pos_next),
            .slot_in   (slot_a[g]),
            .shift_in  (shift_a[g]),
            .wlen_in   (wlen_a[g]),
            .win       (win_a[g])
        );
    end

    assign rx_win   = win_a[0];
    assign tx_win   = win_a[1];
    assign rx_valid = rx_win && bit_en;
    assign rx_dout  = rx_win && rx_din;
    assign tx_oe    = tx_win;
    assign tx_pin   = tx_win && tx_din;
endmodule

// File: rtl/tsg_slot_gate_chk.sv
module tsg_slot_gate_chk #(
    parameter int CNT_W = tsg_pkg::TSG_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             fsync,
    input logic             rx_din,
    input logic             tx_din,
    input logic             rx_win,
    input logic             rx_valid,
    input logic             rx_dout,
    input logic             tx_win,
    input logic             tx_oe,
    input logic             tx_pin,
    input logic [CNT_W-1:0] frame_bit
);
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    logic fs_seen;
    logic edge_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fs_seen <= 1'b1;
        else if (bit_en) fs_seen <= fsync;
    end
    assign edge_now = bit_en && fsync && !fs_seen;

    a_r2_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |=> frame_bit == '0);

    a_r3_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !edge_now && frame_bit != POS_MAX) |=> frame_bit == $past(frame_bit) + 1'b1);

    a_r3_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !edge_now && frame_bit == POS_MAX) |=> frame_bit == POS_MAX);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(frame_bit) && $stable(rx_win) && $stable(tx_win)));

    a_r11_no_frame_no_window: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bit == POS_MAX |-> (!rx_win && !tx_win));

    a_r8_valid_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_win && rx_dout == rx_din));

    a_r8_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_win |-> (!rx_valid && !rx_dout));

    a_r9_tx_drive: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> (tx_win && tx_pin == tx_din));

    a_r9_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> (!tx_win && !tx_pin));
endmodule

bind tsg_slot_gate tsg_slot_gate_chk #(.CNT_W(CNT_W)) u_tsg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .fsync     (fsync),
    .rx_din    (rx_din),
    .tx_din    (tx_din),
    .rx_win    (rx_win),
    .rx_valid  (rx_valid),
    .rx_dout   (rx_dout),
    .tx_win    (tx_win),
    .tx_oe     (tx_oe),
    .tx_pin    (tx_pin),
    .frame_bit (frame_bit)
);

// File: tb/test_tsg_slot_gate.sv
module test_tsg_slot_gate;
    localparam int CLK_PERIOD = 10;
    localparam int POS_MAX    = 4095;
    localparam int NVEC       = 5;
    localparam int FRAME_TICKS = 800;

    // {rx_slot, rx_shift, rx_wlen, tx_slot, tx_shift, tx_wlen}
    localparam logic [33:0] VEC [NVEC] = '{
        {6'd0,  3'd0, 8'd7,   6'd1,  3'd0, 8'd7},
        {6'd63, 3'd7, 8'd255, 6'd0,  3'd0, 8'd0},
        {6'd5,  3'd3, 8'd0,   6'd5,  3'd3, 8'd255},
        {6'd2,  3'd1, 8'd15,  6'd10, 3'd6, 8'd2},
        {6'd0,  3'd0, 8'd255, 6'd63, 3'd0, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        fsync = 1'b1;
    logic [5:0]  rx_slot = '0, tx_slot = '0;
    logic [2:0]  rx_shift = '0, tx_shift = '0;
    logic [7:0]  rx_wlen = '0, tx_wlen = '0;
    logic        rx_din = 1'b0, tx_din = 1'b0;
    logic        rx_win, rx_valid, rx_dout, tx_win, tx_oe, tx_pin;
    logic [11:0] frame_bit;

    tsg_slot_gate i_tsg_slot_gate (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
        .rx_slot(rx_slot), .rx_shift(rx_shift), .rx_wlen(rx_wlen),
        .tx_slot(tx_slot), .tx_shift(tx_shift), .tx_wlen(tx_wlen),
        .rx_din(rx_din), .tx_din(tx_din),
        .rx_win(rx_win), .rx_valid(rx_valid), .rx_dout(rx_dout),
        .tx_win(tx_win), .tx_oe(tx_oe), .tx_pin(tx_pin),
        .frame_bit(frame_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1 reset";

    // reference model
    int m_pos = POS_MAX;
    bit m_fs  = 1'b1;
    int m_rx_st = 0, m_rx_w = 1, m_tx_st = 0, m_tx_w = 1;

    function automatic bit in_win(int pos, int st, int w);
        return (pos != POS_MAX) && (pos >= st) && (pos < st + w);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, tag, act, exp);
        end
    endtask

    task automatic do_tick(bit fs);
        bit er, et;
        @(negedge clk);
        fsync  = fs;
        bit_en = 1'b1;
        rx_din = 1'($urandom);
        tx_din = 1'($urandom);
        #1;
        er = in_win(m_pos, m_rx_st, m_rx_w);
        et = in_win(m_pos, m_tx_st, m_tx_w);
        chk("R8 rx_valid", int'(rx_valid), int'(er));
        chk("R8 rx_dout",  int'(rx_dout),  int'(er & rx_din));
        chk("R9 tx_oe",    int'(tx_oe),    int'(et));
        chk("R9 tx_pin",   int'(tx_pin),   int'(et & tx_din));
        if (fs && !m_fs) begin
            m_pos   = 0;
            m_rx_st = int'(rx_slot) * 8 + int'(rx_shift);
            m_rx_w  = int'(rx_wlen) + 1;
            m_tx_st = int'(tx_slot) * 8 + int'(tx_shift);
            m_tx_w  = int'(tx_wlen) + 1;
        end else if (m_pos != POS_MAX) begin
            m_pos++;
        end
        m_fs = fs;
        @(negedge clk);
        bit_en = 1'b0;
        #1;
        chk("R3 frame_bit", int'(frame_bit), m_pos);
        chk("R4 rx_win", int'(rx_win), int'(in_win(m_pos, m_rx_st, m_rx_w)));
        chk("R5 tx_win", int'(tx_win), int'(in_win(m_pos, m_tx_st, m_tx_w)));
    endtask

    task automatic set_cfg(logic [33:0] v);
        {rx_slot, rx_shift, rx_wlen, tx_slot, tx_shift, tx_wlen} = v;
    endtask

    // watchdog
    bit done = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 frame_bit", int'(frame_bit), POS_MAX);
        chk("R1 rx_win", int'(rx_win), 0);
        chk("R1 tx_win", int'(tx_win), 0);
        chk("R1 tx_oe",  int'(tx_oe), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // fsync high out of reset is no edge; nothing opens before a frame
        phase = "R11 R2 pre-sync";
        set_cfg(VEC[0]);
        repeat (4) do_tick(1'b1);
        repeat (4) do_tick(1'b0);

        // table walk: one frame per vector (R6 widths 1 and 256, max start)
        for (int i = 0; i < NVEC; i++) begin
            phase = $sformatf("R6 vector %0d", i);
            set_cfg(VEC[i]);
            do_tick(1'b1);
            for (int k = 1; k < FRAME_TICKS; k++) do_tick(1'b0);
        end

        // level held high must not retrigger
        phase = "R2 held high";
        set_cfg(VEC[3]);
        repeat (30) do_tick(1'b1);

        // no bit ticks: nothing moves even if fsync toggles
        phase = "R3 no bit_en";
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            fsync = ~fsync;
        end
        #1;
        chk("R3 frame_bit hold", int'(frame_bit), m_pos);
        chk("R3 rx_win hold", int'(rx_win), int'(in_win(m_pos, m_rx_st, m_rx_w)));

        // frame edge inside an open receive window
        phase = "R10 sync in window";
        set_cfg({6'd2, 3'd0, 8'd15, 6'd3, 3'd0, 8'd3});
        do_tick(1'b0);
        do_tick(1'b1);
        for (int k = 0; k < 20; k++) do_tick(1'b0);
        set_cfg({6'd0, 3'd4, 8'd5, 6'd0, 3'd0, 8'd0});
        do_tick(1'b1);
        for (int k = 0; k < 40; k++) do_tick(1'b0);

        // settings changed mid-window apply only from next frame
        phase = "R7 late settings";
        set_cfg({6'd1, 3'd0, 8'd7, 6'd1, 3'd2, 8'd9});
        do_tick(1'b1);
        for (int k = 0; k < 10; k++) do_tick(1'b0);
        set_cfg({6'd0, 3'd0, 8'd0, 6'd4, 3'd0, 8'd0});
        for (int k = 0; k < 30; k++) do_tick(1'b0);
        do_tick(1'b1);
        for (int k = 0; k < 40; k++) do_tick(1'b0);

        // long frame without sync: position saturates
        phase = "R3 saturation";
        for (int k = 0; k < 4100; k++) do_tick(1'b0);
        chk("R3 saturated", int'(frame_bit), POS_MAX);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule